// File: doc/BRIEF.md
# Punctured Rate-1/2 K=7 Soft-Decision Viterbi Decoder

This block recovers the information bits of a 64-state, rate-1/2 convolutional code from 5-bit soft decisions. It accepts one trellis step per input strobe. Each step carries a soft value for the first coded output (X) and one for the second (Y), together with a code-rate select. For the punctured rates, a phase counter marks which of the two positions the transmitter deleted. Those positions are replaced by an erasure that weighs both hypotheses equally. Every step, an add-compare-select stage updates 64 path metrics and stores one decision bit per state in a survivor memory.

After each new step, a serial traceback engine starts at the state with the lowest metric. It walks the survivor memory back 128 steps and releases the bit that sits that far in the past. The decoded bit is then passed through a local copy of the encoder. The result is compared with the hard decisions received for the same step, which are held in a side memory next to the survivor words. Each mismatch at a transmitted position counts as an input bit error. The count saturates and is published at the end of every window of a programmable number of decoded bits.

The block has no input handshake. The traceback takes one clock per step of depth, so the source must space its strobes accordingly.

Top module: `vit_decoder`

## Requirements
- R1: The code uses generators 171 and 133 (octal) over the 7-bit register {u, s5..s0}. Here u is the new bit and s5 is the most recent earlier bit. So X = u^s5^s4^s3^s0 and Y = u^s4^s3^s1^s0, and the encoder starts in the all-zero state. With error-free input, the k-th `out_valid` pulse carries the input bit of step k, counting from 0.
- R2: A soft value of 0 means a confident 0 and 31 means a confident 1. The hard decision is bit 4 of the soft value.
- R3: `rate_sel` selects the rate: 0=1/2, 1=2/3, 2=3/4, 3=5/6, 4=7/8, and codes 5 to 7 act as 1/2. The X/Y transmit masks for successive phases are as follows:
  - 2/3: X 10, Y 11
  - 3/4: X 101, Y 110
  - 5/6: X 10101, Y 11010
  - 7/8: X 1000101, Y 1111010
- R4: The phase starts at 0 on the first step after reset and on any step whose `rate_sel` differs from the previous step's. Otherwise it advances by one, modulo the period. Soft values at deleted positions have no effect on the decoded bits or on the error count.
- R5: At rate 1/2, every soft value is used and no position is erased.
- R6: Sparse, weakly wrong soft values are corrected, so the decoded bits still equal the transmitted data.
- R7: No output is produced for the first 128 steps. After that, each step yields exactly one single-cycle `out_valid` pulse, 130 clocks after the step's strobe.
- R8: The re-encoded bits of each decoded step are compared with that step's received hard decisions at its transmitted positions only. Each mismatch adds one to the window error count.
- R9: After `win_len` decoded bits (0 acts as 1), `err_valid` pulses together with that bit's `out_valid`. `err_count` then shows the window total, and the accumulator restarts at zero.
- R10: The window count saturates at 2^ERR_W-1 and never wraps.
- R11: Path metrics are reduced by a constant whenever the smallest one reaches a threshold. They never overflow, and decoding stays exact across long runs.
- R12: After reset, `out_valid`, `err_valid` and `err_count` are 0.
- R13: Strobes must be at least TB_DEPTH+4 clocks apart. No strobe may arrive while a traceback is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One trellis step is presented |
| in_soft_x | input | 5 | Soft value of the first coded output |
| in_soft_y | input | 5 | Soft value of the second coded output |
| rate_sel | input | 3 | Code-rate select |
| win_len | input | 16 | Error window length in decoded bits |
| out_valid | output | 1 | Decoded bit strobe |
| out_bit | output | 1 | Decoded bit |
| err_valid | output | 1 | Window error count is published |
| err_count | output | ERR_W | Saturated input error count of the last window |

## Verification
Several properties are checked on every cycle:
- `out_valid` is a single-cycle pulse.
- The window publication coincides with a decoded bit.
- The error accumulator never moves down except at a window boundary.
- No path metric approaches the top of its range.
- No strobe lands during a traceback.

Only the bench scenarios can show that the decoded stream is right. It covers every rate, including garbage at deleted positions and weak flipped values. The same scenarios show that the per-window error totals and their saturation match a model built from the encoding equations and the puncturing masks.

// File: rtl/vit_pkg.sv
// Shared constants, types and pure functions of the Viterbi decoder.
// Assumes the trellis state holds the six previous input bits, newest in bit 5.
package vit_pkg;
    localparam int NSTATE = 64;
    localparam int SOFT_W = 5;
    localparam int BM_W   = SOFT_W + 1;

    typedef enum logic [1:0] {TB_IDLE, TB_RUN, TB_EMIT} tb_mode_t;

    // Coded outputs {X, Y} for new bit u entering state s.
    function automatic logic [1:0] enc_out(input logic u, input logic [5:0] s);
        logic [6:0] r;
        r = {u, s};
        return {^(r & 7'b1111001), ^(r & 7'b1011011)};
    endfunction

    // Puncturing period for a rate code.
    function automatic logic [2:0] punct_period(input logic [2:0] rate);
        case (rate)
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd5;
            3'd4:    return 3'd7;
            default: return 3'd1;
        endcase
    endfunction

    // Transmit mask {X, Y} for a rate code and phase.
    function automatic logic [1:0] punct_mask(input logic [2:0] rate, input logic [2:0] ph);
        logic [6:0] xm;
        logic [6:0] ym;
        case (rate)
            3'd1:    begin xm = 7'b0000001; ym = 7'b0000011; end
            3'd2:    begin xm = 7'b0000101; ym = 7'b0000011; end
            3'd3:    begin xm = 7'b0010101; ym = 7'b0001011; end
            3'd4:    begin xm = 7'b1010001; ym = 7'b0101111; end
            default: begin xm = 7'b0000001; ym = 7'b0000001; end
        endcase
        return {xm[ph], ym[ph]};
    endfunction
endpackage

// File: rtl/vit_depunct.sv
// Depuncturer and branch-metric unit.
// Tracks the puncturing phase, erases deleted positions and produces the
// four branch costs indexed by the hypothesis {X, Y}.
// Assumes one input slot per trellis step.
module vit_depunct
    import vit_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SOFT_W-1:0]       soft_x,
    input  logic [SOFT_W-1:0]       soft_y,
    input  logic [2:0]              rate_sel,
    output logic [3:0][BM_W-1:0]    bm,
    output logic [3:0]              side
);
    localparam logic [SOFT_W-1:0] SMAX = {SOFT_W{1'b1}};

    logic [2:0]        rate_q;
    logic [2:0]        phase_q;
    logic [2:0]        ph_use;
    logic [2:0]        ph_inc;
    logic [1:0]        mask;
    logic [SOFT_W-1:0] cx0, cx1, cy0, cy1;

    // Select the phase for this step and the erasure-aware costs.
    always_comb begin
        ph_use = (rate_sel != rate_q) ? 3'd0 : phase_q;
        ph_inc = (ph_use + 3'd1 == punct_period(rate_sel)) ? 3'd0 : ph_use + 3'd1;
        mask   = punct_mask(rate_sel, ph_use);
        cx0    = mask[1] ? soft_x : '0;
        cx1    = mask[1] ? SMAX - soft_x : '0;
        cy0    = mask[0] ? soft_y : '0;
        cy1    = mask[0] ? SMAX - soft_y : '0;
        bm[0]  = BM_W'(cx0) + BM_W'(cy0);
        bm[1]  = BM_W'(cx0) + BM_W'(cy1);
        bm[2]  = BM_W'(cx1) + BM_W'(cy0);
        bm[3]  = BM_W'(cx1) + BM_W'(cy1);
        side   = {mask, soft_x[SOFT_W-1], soft_y[SOFT_W-1]};
    end

    // Advance the puncturing phase on each accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= 3'd0;
            phase_q <= 3'd0;
        end else if (in_valid) begin
            rate_q  <= rate_sel;
            phase_q <= ph_inc;
        end
    end
endmodule

// File: rtl/vit_acs.sv
// Add-compare-select over 64 states with threshold renormalisation.
// Produces the decision word (1 = the odd predecessor won) and the
// state with the lowest updated metric. Ties favour the even predecessor.
module vit_acs
    import vit_pkg::*;
#(
    parameter int MW     = 12,
    parameter int RENORM = 1024,
    parameter int INIT   = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [3:0][BM_W-1:0]  bm,
    output logic [NSTATE-1:0]     dec,
    output logic [5:0]            best,
    output logic [NSTATE*MW-1:0]  pm_flat
);
    localparam logic [MW-1:0] RN_V   = MW'(RENORM);
    localparam logic [MW-1:0] INIT_V = MW'(INIT);

    logic [MW-1:0] pm     [NSTATE];
    logic [MW-1:0] pm_new [NSTATE];
    logic [MW-1:0] cur_min;
    logic          renorm;

    // Find the smallest current metric to decide on renormalisation.
    always_comb begin
        cur_min = pm[0];
        for (int i = 1; i < NSTATE; i++)
            if (pm[i] < cur_min) cur_min = pm[i];
        renorm = (cur_min >= RN_V);
    end

    genvar g;
    generate
        for (g = 0; g < NSTATE; g++) begin : g_acs
            localparam logic [5:0] P0 = 6'((2 * g) % NSTATE);
            localparam logic [5:0] P1 = 6'((2 * g) % NSTATE + 1);
            localparam logic       U  = (g >= NSTATE / 2);
            localparam logic [1:0] O0 = enc_out(U, P0);
            localparam logic [1:0] O1 = enc_out(U, P1);
            logic [MW-1:0] c0, c1, win;
            // Compare the two candidate paths into this state.
            always_comb begin
                c0        = pm[P0] + MW'(bm[O0]);
                c1        = pm[P1] + MW'(bm[O1]);
                dec[g]    = (c1 < c0);
                win       = dec[g] ? c1 : c0;
                pm_new[g] = renorm ? win - RN_V : win;
            end
            assign pm_flat[g*MW +: MW] = pm[g];
        end
    endgenerate

    // Pick the surviving state with the lowest updated metric.
    always_comb begin
        logic [MW-1:0] bv;
        bv   = pm_new[0];
        best = 6'd0;
        for (int i = 1; i < NSTATE; i++)
            if (pm_new[i] < bv) begin
                bv   = pm_new[i];
                best = 6'(i);
            end
    end

    // Hold the path metrics; state 0 starts favoured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTATE; i++)
                pm[i] <= (i == 0) ? '0 : INIT_V;
        end else if (step) begin
            for (int i = 0; i < NSTATE; i++)
                pm[i] <= pm_new[i];
        end
    end
endmodule

// File: rtl/vit_traceback.sv
// Survivor memory, side memory of received hard decisions and masks, and a
// serial traceback engine.
// For every step once TB_DEPTH earlier steps exist, it walks back TB_DEPTH
// decisions from the given start state, one per clock, and then emits the bit
// and side entry of the step that lies TB_DEPTH steps in the past.
// Assumes no new step arrives while a walk is in progress.
module vit_traceback
    import vit_pkg::*;
#(
    parameter int TB_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [NSTATE-1:0] dec_in,
    input  logic [5:0]        best_in,
    input  logic [3:0]        side_in,
    output logic              emit,
    output logic              emit_bit,
    output logic [3:0]        emit_side,
    output logic              busy
);
    localparam int AW    = $clog2(TB_DEPTH) + 1;
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(TB_DEPTH + 1);
    localparam int SEENW = CW + 1;
    localparam logic [CW-1:0]    TB_V   = CW'(TB_DEPTH);
    localparam logic [SEENW-1:0] SEEN_V = SEENW'(TB_DEPTH);

    logic [NSTATE-1:0] surv     [DEPTH];
    logic [3:0]        side_mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     tb_addr;
    logic [5:0]        tb_state;
    logic [CW-1:0]     tb_cnt;
    logic [SEENW-1:0]  seen;
    tb_mode_t          mode;
    logic              rd_bit;

    // Read the decision of the current state at the current step.
    always_comb begin
        rd_bit    = surv[tb_addr][tb_state];
        emit      = (mode == TB_EMIT);
        emit_bit  = tb_state[5];
        emit_side = side_mem[tb_addr];
        busy      = (mode != TB_IDLE);
    end

    // Store the decision word and side entry of each step.
    always_ff @(posedge clk) begin
        if (step) begin
            surv[wr_ptr]     <= dec_in;
            side_mem[wr_ptr] <= side_in;
        end
    end

    // Sequence the traceback walk and its emit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            seen     <= '0;
            mode     <= TB_IDLE;
            tb_addr  <= '0;
            tb_state <= '0;
            tb_cnt   <= '0;
        end else begin
            case (mode)
                TB_RUN: begin
                    tb_state <= {tb_state[4:0], rd_bit};
                    tb_addr  <= tb_addr - 1'b1;
                    tb_cnt   <= tb_cnt - 1'b1;
                    if (tb_cnt == CW'(1)) mode <= TB_EMIT;
                end
                TB_EMIT: mode <= TB_IDLE;
                default: mode <= TB_IDLE;
            endcase
            if (step) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (seen != SEEN_V) seen <= seen + 1'b1;
                if (seen == SEEN_V) begin
                    mode     <= TB_RUN;
                    tb_addr  <= wr_ptr;
                    tb_state <= best_in;
                    tb_cnt   <= TB_V;
                end
            end
        end
    end
endmodule

// File: rtl/vit_reencode.sv
// Re-encoder and input error counter.
// Re-encodes each emitted bit, compares it with the delayed hard decisions at
// the transmitted positions, and accumulates mismatches with saturation over
// a window of win_len decoded bits (0 acts as 1).
module vit_reencode
    import vit_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emit,
    input  logic             emit_bit,
    input  logic [3:0]       emit_side,
    input  logic [WIN_W-1:0] win_len,
    output logic             out_valid,
    output logic             out_bit,
    output logic             err_valid,
    output logic [ERR_W-1:0] err_count,
    output logic [ERR_W-1:0] acc_o
);
    localparam logic [ERR_W+1:0] SAT_V = {2'b00, {ERR_W{1'b1}}};

    logic [5:0]       enc_s;
    logic [ERR_W-1:0] acc;
    logic [WIN_W-1:0] win_cnt;
    logic [1:0]       g;
    logic [1:0]       nerr;
    logic [ERR_W+1:0] sum;
    logic [ERR_W-1:0] sat;
    logic             last;

    // Count mismatches of this bit and form the saturated running total.
    always_comb begin
        g    = enc_out(emit_bit, enc_s);
        nerr = 2'(emit_side[3] & (g[1] ^ emit_side[1]))
             + 2'(emit_side[2] & (g[0] ^ emit_side[0]));
        sum  = (ERR_W+2)'(acc) + (ERR_W+2)'(nerr);
        sat  = (sum > SAT_V) ? {ERR_W{1'b1}} : sum[ERR_W-1:0];
        last = ((WIN_W+1)'(win_cnt) + 1'b1 >= (WIN_W+1)'(win_len));
        acc_o = acc;
    end

    // Register outputs, advance the re-encoder and close windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_s     <= '0;
            acc       <= '0;
            win_cnt   <= '0;
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            err_valid <= 1'b0;
            err_count <= '0;
        end else begin
            out_valid <= emit;
            err_valid <= 1'b0;
            if (emit) begin
                out_bit <= emit_bit;
                enc_s   <= {emit_bit, enc_s[5:1]};
                if (last) begin
                    err_count <= sat;
                    err_valid <= 1'b1;
                    acc       <= '0;
                    win_cnt   <= '0;
                end else begin
                    acc     <= sat;
                    win_cnt <= win_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vit_decoder.sv
// Top level of the punctured K=7 Viterbi decoder.
// Chains depuncturer, add-compare-select, survivor memory with traceback,
// and re-encoder/error counter. Assumes strobes are at least TB_DEPTH+4
// clocks apart.
module vit_decoder
    import vit_pkg::*;
#(
    parameter int TB_DEPTH = 128,
    parameter int MW       = 12,
    parameter int RENORM   = 1024,
    parameter int ERR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        in_soft_x,
    input  logic [4:0]        in_soft_y,
    input  logic [2:0]        rate_sel,
    input  logic [15:0]       win_len,
    output logic              out_valid,
    output logic              out_bit,
    output logic              err_valid,
    output logic [ERR_W-1:0]  err_count
);
    logic [3:0][BM_W-1:0] bm;
    logic [3:0]           side;
    logic [NSTATE-1:0]    dec;
    logic [5:0]           best;
    logic [NSTATE*MW-1:0] pm_flat;
    logic                 emit;
    logic                 emit_bit;
    logic [3:0]           emit_side;
    logic                 tb_busy;
    logic [ERR_W-1:0]     err_acc;

    vit_depunct u_dep (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .soft_x(in_soft_x), .soft_y(in_soft_y), .rate_sel(rate_sel),
        .bm(bm), .side(side)
    );

    vit_acs #(.MW(MW), .RENORM(RENORM)) u_acs (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .bm(bm),
        .dec(dec), .best(best), .pm_flat(pm_flat)
    );

    vit_traceback #(.TB_DEPTH(TB_DEPTH)) u_tb (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .dec_in(dec),
        .best_in(best), .side_in(side), .emit(emit), .emit_bit(emit_bit),
        .emit_side(emit_side), .busy(tb_busy)
    );

    vit_reencode #(.ERR_W(ERR_W), .WIN_W(16)) u_re (
        .clk(clk), .rst_n(rst_n), .emit(emit), .emit_bit(emit_bit),
        .emit_side(emit_side), .win_len(win_len), .out_valid(out_valid),
        .out_bit(out_bit), .err_valid(err_valid), .err_count(err_count),
        .acc_o(err_acc)
    );
endmodule

// File: rtl/vit_chk.sv
// Cycle-level checks of the decoder, attached to the top through bind.
module vit_chk #(
    parameter int MW    = 12,
    parameter int ERR_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                tb_busy,
    input logic                out_valid,
    input logic                err_valid,
    input logic [ERR_W-1:0]    err_acc,
    input logic [64*MW-1:0]    pm_flat
);
    localparam logic [MW-1:0] LIMIT = MW'((1 << MW) - 64);
    logic [MW-1:0] pm_max;

    // Largest path metric for the overflow check.
    always_comb begin
        pm_max = '0;
        for (int i = 0; i < 64; i++)
            if (pm_flat[i*MW +: MW] > pm_max) pm_max = pm_flat[i*MW +: MW];
    end

    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    err_with_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> out_valid);

    // R10
    acc_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> err_acc >= $past(err_acc));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_max < LIMIT);

    // R13
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !tb_busy);
endmodule

bind vit_decoder vit_chk #(.MW(MW), .ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tb_busy(tb_busy),
    .out_valid(out_valid), .err_valid(err_valid), .err_acc(err_acc),
    .pm_flat(pm_flat)
);

// File: tb/tb_vit_decoder.sv
// Bench for vit_decoder: seeded random data over every rate, garbage at
// deleted positions and weak flips, checked against a bench-side model.
module tb_vit_decoder;
    localparam int D      = 128;
    localparam int ERR_W  = 3;
    localparam int SEG    = 60;
    localparam int NDATA  = 5 * SEG;
    localparam int NSTEP  = NDATA + D;
    localparam int WIN    = 40;
    localparam int SATMAX = (1 << ERR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [4:0]       in_soft_x = '0;
    logic [4:0]       in_soft_y = '0;
    logic [2:0]       rate_sel = '0;
    logic [15:0]      win_len = 16'(WIN);
    logic             out_valid;
    logic             out_bit;
    logic             err_valid;
    logic [ERR_W-1:0] err_count;

    always #2.5 clk = ~clk;

    vit_decoder #(.ERR_W(ERR_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_soft_x(in_soft_x), .in_soft_y(in_soft_y), .rate_sel(rate_sel),
        .win_len(win_len), .out_valid(out_valid), .out_bit(out_bit),
        .err_valid(err_valid), .err_count(err_count)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic data_b [NSTEP];
    logic [4:0] sx_a [NSTEP];
    logic [4:0] sy_a [NSTEP];
    logic [2:0] rate_a [NSTEP];
    int   errs_a [NSTEP];
    int   out_idx = 0;
    int   win_acc = 0;
    int   win_n = 0;
    int   late_ok = 0;
    int   seg_bad = 0;

    // R3 masks {X,Y} per rate and phase.
    function automatic logic [1:0] mask_of(input int r, input int ph);
        string xs, ys;
        case (r)
            1: begin xs = "10";      ys = "11";      end
            2: begin xs = "101";     ys = "110";     end
            3: begin xs = "10101";   ys = "11010";   end
            4: begin xs = "1000101"; ys = "1111010"; end
            default: begin xs = "1"; ys = "1";       end
        endcase
        return {xs[ph] == "1", ys[ph] == "1"};
    endfunction

    function automatic int period_of(input int r);
        return (r == 1) ? 2 : (r == 2) ? 3 : (r == 3) ? 5 : (r == 4) ? 7 : 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Build the step stream from the encoding rules of R1 and R3.
    task automatic build();
        logic [5:0] s = '0;
        int prev_r = 0;
        int ph = 0;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NSTEP; i++) begin
            int  r;
            int  use_ph;
            bit  gx, gy, u;
            logic [1:0] m;
            int  e = 0;
            r = (i < NDATA) ? i / SEG : 0;
            u = (i < NDATA) ? 1'($urandom % 2) : 1'b0;
            use_ph = (r != prev_r) ? 0 : ph;
            m = mask_of(r, use_ph);
            gx = u ^ s[5] ^ s[4] ^ s[3] ^ s[0];
            gy = u ^ s[4] ^ s[3] ^ s[1] ^ s[0];
            s = {u, s[5:1]};
            sx_a[i] = m[1] ? (gx ? 5'd25 : 5'd6) : 5'($urandom % 32);
            sy_a[i] = m[0] ? (gy ? 5'd25 : 5'd6) : 5'($urandom % 32);
            // R6 weak flips: dense in the rate 1/2 part, sparser at 2/3.
            if ((r == 0 && i < NDATA && $urandom % 4 == 0) ||
                (r == 1 && $urandom % 10 == 0)) begin
                if (m[1] && ($urandom % 2 == 0 || !m[0])) begin
                    sx_a[i] = gx ? 5'd14 : 5'd17; e = 1;
                end else if (m[0]) begin
                    sy_a[i] = gy ? 5'd14 : 5'd17; e = 1;
                end
            end
            data_b[i] = u;
            rate_a[i] = 3'(r);
            errs_a[i] = e;
            prev_r = r;
            ph = (use_ph + 1 == period_of(r)) ? 0 : use_ph + 1;
        end
    endtask

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                string tag;
                tag = (out_idx < SEG) ? "R1 R2 R5" : "R1 R2 R3 R4";
                if (out_idx < NDATA) begin
                    check(out_bit == data_b[out_idx], tag, out_bit, data_b[out_idx]);
                    if (out_bit != data_b[out_idx] && out_idx < 2 * SEG) seg_bad++;
                    if (out_idx >= NDATA - 50 && out_bit == data_b[out_idx]) late_ok++;
                    // R8 R9 R10 window model
                    win_acc += errs_a[out_idx];
                    if (win_acc > SATMAX) win_acc = SATMAX;
                    win_n++;
                    if (win_n == WIN) begin
                        check(err_valid == 1'b1, "R9", err_valid, 1);
                        check(int'(err_count) == win_acc, "R8 R10", err_count, win_acc);
                        win_acc = 0;
                        win_n = 0;
                    end else begin
                        check(err_valid == 1'b0, "R9", err_valid, 0);
                    end
                end
                out_idx++;
            end else begin
                check(err_valid == 1'b0, "R9", err_valid, 0);
            end
        end
    end

    initial begin
        build();
        repeat (4) @(negedge clk);
        // R12 reset state
        check(out_valid == 1'b0, "R12", out_valid, 0);
        check(err_valid == 1'b0, "R12", err_valid, 0);
        check(err_count == '0, "R12", err_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NSTEP; i++) begin
            in_valid  = 1'b1;
            in_soft_x = sx_a[i];
            in_soft_y = sy_a[i];
            rate_sel  = rate_a[i];
            @(negedge clk);
            in_valid  = 1'b0;
            in_soft_x = 5'($urandom % 32);
            in_soft_y = 5'($urandom % 32);
            repeat (D + 6) @(negedge clk);
            // R7 R13 one output per step once D steps are stored
            check(out_idx == ((i >= D) ? i - D + 1 : 0), "R7 R13", out_idx,
                  (i >= D) ? i - D + 1 : 0);
        end
        check(out_idx == NDATA, "R7", out_idx, NDATA);
        check(seg_bad == 0, "R6", seg_bad, 0);
        check(late_ok == 50, "R11", late_ok, 50);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", out_idx, NDATA);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule